// File: doc/BRIEF.md
# LPC Bus Error Flag and Receive-Interrupt Enable Register

This block is a small status and control register on the slave side of an LPC host interface. It watches two bus pins. A falling edge on the power-down request pin sets a sticky shutdown flag. A falling edge on the frame pin while a transfer cycle is in progress sets a sticky abort flag. Either flag raises a single error interrupt request. Slave software clears a flag in two steps. It first reads the register and sees the flag at 1. It then writes 0 to that bit.

The same register holds an enable bit for the receive-complete interrupt of data channel 3. A separate mode input selects which events that enable gates. In one mode it gates only the input-data receive event. In the other mode it gates both the input-data receive event and the two-way-register receive event. The register is reached through a simple slave read/write port. LPC cycle decoding and the data registers themselves are outside this block.

Top module: `lpc_errflag_reg`

## Requirements
- R1: After chip reset (rstN low), the register reads 0x00, and both errIrq and rxIrq are 0.
- R2: A falling edge on pwrDownPinN sets the shutdown flag, which reads in bit 5. The pin passes through a two-stage synchronizer and an edge register, so the flag shows at most 4 clocks after the edge. The flag then holds after the pin returns high.
- R3: A falling edge on framePinN sets the abort flag (bit 4) only if xferActive is high when the synchronized edge is detected. An edge seen while xferActive is low leaves the flag at 0.
- R4: errIrq is 1 exactly when at least one of the two flags is 1.
- R5: A register write whose data bit is 0 clears a flag only if the last register access before that write was a read that returned the flag as 1. A write of 0 without such a read leaves the flag set.
- R6: Writing 1 to a flag bit never sets it. Any register write uses up the read-1 qualification, so a later write of 0 with no fresh read does not clear the flag.
- R7: A pulse on lpcHwReset or on lpcSwReset clears both flags.
- R8: A pulse on lpcHwShutdown or on lpcSwShutdown clears the abort flag and leaves the shutdown flag unchanged.
- R9: Bit 3 is a read/write receive-interrupt enable. With twrMode at 0, rxIrq equals enable AND idrRxDone, and twrRxDone has no effect.
- R10: With twrMode at 1, rxIrq equals enable AND (idrRxDone OR twrRxDone).
- R11: If a flag's set event and a qualified clearing write happen in the same clock, the flag stays 1.
- R12: Bits 7:6 and 2:0 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous chip reset, active low |
| framePinN | input | 1 | LPC frame pin, asynchronous |
| pwrDownPinN | input | 1 | LPC power-down request pin, asynchronous |
| xferActive | input | 1 | High while an LPC transfer cycle is in progress |
| lpcHwReset | input | 1 | LPC hardware reset pulse |
| lpcSwReset | input | 1 | LPC software reset pulse |
| lpcHwShutdown | input | 1 | LPC hardware shutdown pulse |
| lpcSwShutdown | input | 1 | LPC software shutdown pulse |
| idrRxDone | input | 1 | Channel-3 input data register receive event |
| twrRxDone | input | 1 | Two-way-register receive event |
| twrMode | input | 1 | Adds the two-way-register event to the gated set when 1 |
| regSel | input | 1 | Register select |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data; 0 when not reading |
| errIrq | output | 1 | Error interrupt request |
| rxIrq | output | 1 | Receive-complete interrupt request |

## Verification
Each flag is set with its pin edge both inside and outside a transfer cycle, which separates the qualified abort source from the unqualified power-down source. Clearing writes are tried in three sequences: without a prior read, after a read that returned 1, and after a read followed by an intervening write. Together these show that the read-1 qualification is needed and is used up by any write. The reset and shutdown controls are pulsed with both flags set, which shows which flag each control clears. The receive enable is swept across both values of the mode input and each receive event alone, which shows whether the two-way event is masked.

// File: rtl/lpc_errflag_pkg.sv
package lpc_errflag_pkg;
  localparam int REG_W  = 8;
  localparam int PD_BIT = 5;
  localparam int AB_BIT = 4;
  localparam int EN_BIT = 3;

  typedef struct packed {
    logic pdSet;
    logic abSet;
    logic pdClr;
    logic abClr;
    logic pdRst;
    logic abRst;
    logic enWr;
    logic enVal;
  } flagCtl_t;
endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic fallPulse
);
  logic [STAGES-1:0] chain;
  logic prevLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= '1;
      prevLvl <= 1'b1;
    end else begin
      chain   <= {chain[STAGES-2:0], pinIn};
      prevLvl <= chain[STAGES-1];
    end
  end

  assign fallPulse = prevLvl & ~chain[STAGES-1];
endmodule

// File: rtl/lpc_errflag_ctl.sv
module lpc_errflag_ctl
  import lpc_errflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePinN,
  input  logic             pwrDownPinN,
  input  logic             xferActive,
  input  logic             lpcHwReset,
  input  logic             lpcSwReset,
  input  logic             lpcHwShutdown,
  input  logic             lpcSwShutdown,
  input  logic             regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] wrData,
  input  logic             pdFlag,
  input  logic             abFlag,
  output flagCtl_t         ctl
);
  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pinVec;
  logic [NUM_PINS-1:0] fallVec;
  logic pdArm, abArm;
  logic wrStb, rdStb;

  assign pinVec = {framePinN, pwrDownPinN};

  for (genvar i = 0; i < NUM_PINS; i++) begin : gPin
    pin_edge_sync #(.STAGES(SYNC_STAGES)) uSync (
      .clk      (clk),
      .rstN     (rstN),
      .pinIn    (pinVec[i]),
      .fallPulse(fallVec[i])
    );
  end

  assign wrStb = regSel & regWr;
  assign rdStb = regSel & regRd & ~regWr;

  always_comb begin
    ctl.pdRst = lpcHwReset | lpcSwReset;
    ctl.abRst = lpcHwReset | lpcSwReset | lpcHwShutdown | lpcSwShutdown;
    ctl.pdSet = fallVec[0];
    ctl.abSet = fallVec[1] & xferActive;
    ctl.pdClr = wrStb & pdArm & ~wrData[PD_BIT];
    ctl.abClr = wrStb & abArm & ~wrData[AB_BIT];
    ctl.enWr  = wrStb;
    ctl.enVal = wrData[EN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdArm <= 1'b0;
      abArm <= 1'b0;
    end else begin
      if (ctl.pdRst || wrStb) pdArm <= 1'b0;
      else if (rdStb)         pdArm <= pdFlag;
      if (ctl.abRst || wrStb) abArm <= 1'b0;
      else if (rdStb)         abArm <= abFlag;
    end
  end
endmodule

// File: rtl/lpc_errflag_dp.sv
module lpc_errflag_dp
  import lpc_errflag_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  flagCtl_t         ctl,
  input  logic             regSel,
  input  logic             regRd,
  input  logic             idrRxDone,
  input  logic             twrRxDone,
  input  logic             twrMode,
  output logic             pdFlag,
  output logic             abFlag,
  output logic             rxIntEn,
  output logic [REG_W-1:0] rdData,
  output logic             errIrq,
  output logic             rxIrq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdFlag  <= 1'b0;
      abFlag  <= 1'b0;
      rxIntEn <= 1'b0;
    end else begin
      if (ctl.pdRst)      pdFlag <= 1'b0;
      else if (ctl.pdSet) pdFlag <= 1'b1;
      else if (ctl.pdClr) pdFlag <= 1'b0;

      if (ctl.abRst)      abFlag <= 1'b0;
      else if (ctl.abSet) abFlag <= 1'b1;
      else if (ctl.abClr) abFlag <= 1'b0;

      if (ctl.enWr) rxIntEn <= ctl.enVal;
    end
  end

  always_comb begin
    rdData = '0;
    if (regSel && regRd) begin
      rdData[PD_BIT] = pdFlag;
      rdData[AB_BIT] = abFlag;
      rdData[EN_BIT] = rxIntEn;
    end
  end

  assign errIrq = pdFlag | abFlag;
  assign rxIrq  = rxIntEn & (idrRxDone | (twrMode & twrRxDone));
endmodule

// File: rtl/lpc_errflag_reg.sv
module lpc_errflag_reg
  import lpc_errflag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePinN,
  input  logic             pwrDownPinN,
  input  logic             xferActive,
  input  logic             lpcHwReset,
  input  logic             lpcSwReset,
  input  logic             lpcHwShutdown,
  input  logic             lpcSwShutdown,
  input  logic             idrRxDone,
  input  logic             twrRxDone,
  input  logic             twrMode,
  input  logic             regSel,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             errIrq,
  output logic             rxIrq
);
  flagCtl_t ctl;
  logic pdFlag, abFlag, rxIntEn;

  lpc_errflag_ctl #(.SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .framePinN    (framePinN),
    .pwrDownPinN  (pwrDownPinN),
    .xferActive   (xferActive),
    .lpcHwReset   (lpcHwReset),
    .lpcSwReset   (lpcSwReset),
    .lpcHwShutdown(lpcHwShutdown),
    .lpcSwShutdown(lpcSwShutdown),
    .regSel       (regSel),
    .regWr        (regWr),
    .regRd        (regRd),
    .wrData       (wrData),
    .pdFlag       (pdFlag),
    .abFlag       (abFlag),
    .ctl          (ctl)
  );

  lpc_errflag_dp uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .regSel   (regSel),
    .regRd    (regRd),
    .idrRxDone(idrRxDone),
    .twrRxDone(twrRxDone),
    .twrMode  (twrMode),
    .pdFlag   (pdFlag),
    .abFlag   (abFlag),
    .rxIntEn  (rxIntEn),
    .rdData   (rdData),
    .errIrq   (errIrq),
    .rxIrq    (rxIrq)
  );
endmodule

// File: rtl/lpc_errflag_chk.sv
module lpc_errflag_chk (
  input logic       clk,
  input logic       rstN,
  input logic       xferActive,
  input logic       lpcHwReset,
  input logic       lpcSwReset,
  input logic       lpcHwShutdown,
  input logic       lpcSwShutdown,
  input logic       idrRxDone,
  input logic       twrMode,
  input logic       regSel,
  input logic       regWr,
  input logic       regRd,
  input logic [7:0] rdData,
  input logic       errIrq,
  input logic       rxIrq,
  input logic       pdFlag,
  input logic       abFlag
);
  // R5
  pd_fall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pdFlag) |-> $past((regSel && regWr) || lpcHwReset || lpcSwReset));

  // R8
  ab_fall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(abFlag) |-> $past((regSel && regWr) || lpcHwReset || lpcSwReset
                            || lpcHwShutdown || lpcSwShutdown));

  // R3
  ab_rise_xfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abFlag) |-> $past(xferActive));

  // R7
  lpc_rst_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpcHwReset || lpcSwReset) |=> !errIrq);

  // R9
  twr_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!twrMode && !idrRxDone) |-> !rxIrq);

  // R12
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && regRd) |-> (rdData[7:6] == 2'b00 && rdData[2:0] == 3'b000));
endmodule

bind lpc_errflag_reg lpc_errflag_chk uChk (
  .clk          (clk),
  .rstN         (rstN),
  .xferActive   (xferActive),
  .lpcHwReset   (lpcHwReset),
  .lpcSwReset   (lpcSwReset),
  .lpcHwShutdown(lpcHwShutdown),
  .lpcSwShutdown(lpcSwShutdown),
  .idrRxDone    (idrRxDone),
  .twrMode      (twrMode),
  .regSel       (regSel),
  .regWr        (regWr),
  .regRd        (regRd),
  .rdData       (rdData),
  .errIrq       (errIrq),
  .rxIrq        (rxIrq),
  .pdFlag       (pdFlag),
  .abFlag       (abFlag)
);

// File: tb/tb_lpc_errflag_reg.sv
module tb_lpc_errflag_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic framePinN = 1'b1, pwrDownPinN = 1'b1, xferActive = 1'b0;
  logic lpcHwReset = 1'b0, lpcSwReset = 1'b0, lpcHwShutdown = 1'b0, lpcSwShutdown = 1'b0;
  logic idrRxDone = 1'b0, twrRxDone = 1'b0, twrMode = 1'b0;
  logic regSel = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic errIrq, rxIrq;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_errflag_reg dut (
    .clk(clk), .rstN(rstN), .framePinN(framePinN), .pwrDownPinN(pwrDownPinN),
    .xferActive(xferActive), .lpcHwReset(lpcHwReset), .lpcSwReset(lpcSwReset),
    .lpcHwShutdown(lpcHwShutdown), .lpcSwShutdown(lpcSwShutdown),
    .idrRxDone(idrRxDone), .twrRxDone(twrRxDone), .twrMode(twrMode),
    .regSel(regSel), .regWr(regWr), .regRd(regRd), .wrData(wrData),
    .rdData(rdData), .errIrq(errIrq), .rxIrq(rxIrq)
  );

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected item per read cycle.
  initial forever begin
    @(negedge clk);
    #1;
    if (regSel && regRd) begin
      if (expQ.size() == 0) chk("scoreboard-empty", 8'h01, 8'h00);
      else chk(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doRead(logic [7:0] exp, string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    regSel = 1'b1; regRd = 1'b1;
    @(negedge clk);
    regSel = 1'b0; regRd = 1'b0;
  endtask

  task automatic doWrite(logic [7:0] d);
    @(negedge clk);
    regSel = 1'b1; regWr = 1'b1; wrData = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; wrData = 8'h00;
  endtask

  task automatic pdEdge();
    @(negedge clk); pwrDownPinN = 1'b0;
    idle(4);
    pwrDownPinN = 1'b1;
    idle(3);
  endtask

  task automatic frEdge(logic inXfer);
    @(negedge clk); xferActive = inXfer; framePinN = 1'b0;
    idle(4);
    framePinN = 1'b1; xferActive = 1'b0;
    idle(3);
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: lpcHwReset = 1'b1;
      1: lpcSwReset = 1'b1;
      2: lpcHwShutdown = 1'b1;
      default: lpcSwShutdown = 1'b1;
    endcase
    @(negedge clk);
    lpcHwReset = 1'b0; lpcSwReset = 1'b0; lpcHwShutdown = 1'b0; lpcSwShutdown = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    chk("watchdog", 8'h01, 8'h00);
    report();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1
    chk("R1 errIrq", {7'b0, errIrq}, 8'h00);
    chk("R1 rxIrq", {7'b0, rxIrq}, 8'h00);
    doRead(8'h00, "R1 reset value");

    // R2 / R4: shutdown flag set, sticky after pin rises
    pdEdge();
    chk("R4 errIrq pd", {7'b0, errIrq}, 8'h01);
    // R5: write 0 without a prior read has no effect
    doWrite(8'h00);
    doRead(8'h20, "R5 no-read write ignored / R2 sticky");
    // R6: intervening write uses up the qualification
    doWrite(8'h20);
    doWrite(8'h00);
    doRead(8'h20, "R6 qualification consumed");
    // R5: read-1 then write 0 clears
    doWrite(8'h00);
    chk("R4 errIrq cleared", {7'b0, errIrq}, 8'h00);
    doRead(8'h00, "R5 qualified clear");
    // R6: writing ones never sets flags
    doWrite(8'h30);
    doRead(8'h00, "R6 write 1 no set");
    // R12: unused bits ignore writes
    doWrite(8'hC7);
    doRead(8'h00, "R12 unused bits");

    // R3: frame edge outside transfer ignored
    frEdge(1'b0);
    doRead(8'h00, "R3 edge outside transfer");
    frEdge(1'b1);
    doRead(8'h10, "R3 edge inside transfer");
    chk("R4 errIrq ab", {7'b0, errIrq}, 8'h01);

    // R11: set and qualified clear in the same clock (abort armed by read above)
    @(negedge clk); xferActive = 1'b1; framePinN = 1'b0;
    @(negedge clk);
    @(negedge clk); regSel = 1'b1; regWr = 1'b1; wrData = 8'h00;
    @(negedge clk); regSel = 1'b0; regWr = 1'b0;
    idle(2);
    framePinN = 1'b1; xferActive = 1'b0;
    idle(3);
    doRead(8'h10, "R11 set beats clear");

    // R8: shutdown clears abort only
    pdEdge();
    pulse(2);
    doRead(8'h20, "R8 hw shutdown");
    frEdge(1'b1);
    pulse(3);
    doRead(8'h20, "R8 sw shutdown");
    // R7: LPC resets clear both
    frEdge(1'b1);
    pulse(1);
    doRead(8'h00, "R7 sw reset");
    pdEdge();
    frEdge(1'b1);
    pulse(0);
    doRead(8'h00, "R7 hw reset");
    chk("R7 errIrq", {7'b0, errIrq}, 8'h00);

    // R9 / R10: receive interrupt gating
    idrRxDone = 1'b1;
    idle(1);
    chk("R9 disabled idr", {7'b0, rxIrq}, 8'h00);
    doWrite(8'h08);
    doRead(8'h08, "R9 enable readback");
    chk("R9 enabled idr", {7'b0, rxIrq}, 8'h01);
    idrRxDone = 1'b0; twrRxDone = 1'b1; twrMode = 1'b0;
    idle(1);
    chk("R9 twr masked", {7'b0, rxIrq}, 8'h00);
    twrMode = 1'b1;
    idle(1);
    chk("R10 twr gated in", {7'b0, rxIrq}, 8'h01);
    doWrite(8'h00);
    chk("R10 disabled twr", {7'b0, rxIrq}, 8'h00);
    twrRxDone = 1'b0; twrMode = 1'b0;

    idle(3);
    report();
  end
endmodule